// File: doc/BRIEF.md
# Gated Peripheral Clock Divider

This block turns one of two free-running tick streams into a single-cycle clock-enable strobe for one peripheral, such as an audio serial port, an SPI master, a card interface, a USB host controller or a display pixel engine. One stream comes from the external reference and the other from the PLL. A register port holds a source select, a gate bit and a divisor field. A level input chooses whether the PLL stream is used at its full rate or thinned to every second tick.

With the external reference selected, the strobe follows the reference ticks directly and the divisor has no effect. With the PLL selected, one strobe is produced for every N+1 accepted PLL ticks, where N is the programmed divisor. A set gate bit holds the strobe low. The source may only be changed while the output is gated. Leaving the gated state restarts the count from zero, so the first period after the gate opens is a whole one.

Top module: `periph_clk_div`

## Requirements
- R1: After reset the readback is source = external (0), gate = 1 and divisor = 0, and no strobe is produced.
- R2: While the stored gate bit (register bit DIV_W) is 1, clk_stb stays low whatever the ticks do.
- R3: With source = 0 (register bit DIV_W+1 clear) and gate clear, clk_stb in each cycle equals ext_tick of the previous cycle, whatever the divisor holds.
- R4: With source = 1, pll_full = 1 and divisor N, exactly one strobe is produced for each N+1 PLL ticks.
- R5: With source = 1, pll_full = 0 and divisor N, only every second PLL tick is counted, giving one strobe per 2*(N+1) PLL ticks, the first accepted tick after ungating being the second one.
- R6: A write that would change the source while the stored gate bit is 0 leaves the source unchanged. Gate and divisor still update.
- R7: After a write clears the gate, the count starts at zero. With full rate and divisor N, the first strobe follows the (N+1)-th PLL tick.
- R8: cfg_rdata returns {source, gate, divisor} in bits DIV_W+1, DIV_W and DIV_W-1:0. A write takes effect in the readback on the next cycle.
- R9: If the divisor is lowered to a value at or below the current count, the next counted tick produces a strobe and restarts the count.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ext_tick | input | 1 | Tick enable from the external reference |
| pll_tick | input | 1 | Tick enable from the PLL |
| pll_full | input | 1 | 1 selects the full PLL rate, 0 selects half rate |
| cfg_we | input | 1 | Register write strobe |
| cfg_wdata | input | DIV_W+2 | Write data {source, gate, divisor} |
| cfg_rdata | output | DIV_W+2 | Readback {source, gate, divisor} |
| clk_stb | output | 1 | Divided single-cycle clock enable |

## Verification
A divisor write and a counted PLL tick can fall in the same cycle. When the divisor is lowered beneath the running count, that collision decides whether the counter wraps past its terminal value. The bench sets up this case by running part of a long period, writing a smaller divisor, and then applying one tick. It expects a strobe from that very tick and then a full new period. A second collision is a gate release together with the half-rate phase. The bench checks this by counting strobes over a fixed window from the release, which pins the phase at which counting starts.

// File: rtl/periph_clk_div_pkg.sv
// Shared definitions for the gated peripheral clock divider.
// Assumes the register word is {source, gate, divisor} from MSB down.
package periph_clk_div_pkg;
    typedef enum logic {
        SRC_EXT = 1'b0,
        SRC_PLL = 1'b1
    } src_sel_e;

    // Width of the register word for a given divisor width.
    function automatic int unsigned reg_width(input int unsigned div_w);
        return div_w + 2;
    endfunction
endpackage

// File: rtl/pcd_cfg_reg.sv
// Configuration register: holds source, gate and divisor.
// Assumes a source change is only accepted while the stored gate is set.
module pcd_cfg_reg
    import periph_clk_div_pkg::*;
#(
    parameter int unsigned DIV_W = 9
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we,
    input  logic             wr_src,
    input  logic             wr_gate,
    input  logic [DIV_W-1:0] wr_div,
    output src_sel_e         src_o,
    output logic             gate_o,
    output logic [DIV_W-1:0] div_o
);
    // Register update with the source guarded by the current gate state.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            src_o  <= SRC_EXT;
            gate_o <= 1'b1;
            div_o  <= '0;
        end else if (we) begin
            gate_o <= wr_gate;
            div_o  <= wr_div;
            if (gate_o)
                src_o <= src_sel_e'(wr_src);
        end
    end
endmodule

// File: rtl/pcd_prescale.sv
// Optional halving of the PLL tick stream.
// Assumes the phase is cleared while gated so counting restarts cleanly.
module pcd_prescale (
    input  logic clk,
    input  logic rst_n,
    input  logic hold,
    input  logic pll_tick,
    input  logic pll_full,
    output logic tick_o
);
    logic phase_q;

    // Phase toggles on every PLL tick, cleared while held.
    always_ff @(posedge clk) begin
        if (!rst_n || hold)
            phase_q <= 1'b0;
        else if (pll_tick)
            phase_q <= ~phase_q;
    end

    // Pass every tick at full rate, every second tick at half rate.
    always_comb tick_o = pll_tick && (pll_full || phase_q);
endmodule

// File: rtl/pcd_divider.sv
// Divide-by-(N+1) counter with an external bypass path and a gate.
// Assumes the tick inputs are single-cycle enables in the clk domain.
module pcd_divider
    import periph_clk_div_pkg::*;
#(
    parameter int unsigned DIV_W = 9
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             gate,
    input  src_sel_e         src,
    input  logic             ext_tick,
    input  logic             pll_tick,
    input  logic [DIV_W-1:0] div,
    output logic             stb
);
    logic [DIV_W-1:0] cnt_q;
    logic             term;

    // Terminal count also catches a divisor lowered below the count.
    always_comb term = (cnt_q >= div);

    // Count accepted PLL ticks; restart from zero while gated.
    always_ff @(posedge clk) begin
        if (!rst_n || gate)
            cnt_q <= '0;
        else if (src == SRC_PLL && pll_tick)
            cnt_q <= term ? '0 : cnt_q + 1'b1;
    end

    // Registered strobe from the selected path.
    always_ff @(posedge clk) begin
        if (!rst_n || gate)
            stb <= 1'b0;
        else if (src == SRC_EXT)
            stb <= ext_tick;
        else
            stb <= pll_tick && term;
    end
endmodule

// File: rtl/periph_clk_div.sv
// Top of the gated peripheral clock divider.
// Assumes all tick inputs are synchronous to clk.
module periph_clk_div
    import periph_clk_div_pkg::*;
#(
    parameter int unsigned DIV_W = 9
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ext_tick,
    input  logic             pll_tick,
    input  logic             pll_full,
    input  logic             cfg_we,
    input  logic [DIV_W+1:0] cfg_wdata,
    output logic [DIV_W+1:0] cfg_rdata,
    output logic             clk_stb
);
    localparam int unsigned GATE_BIT = DIV_W;
    localparam int unsigned SRC_BIT  = DIV_W + 1;
    localparam int unsigned RW       = reg_width(DIV_W);

    src_sel_e         src;
    logic             gate;
    logic [DIV_W-1:0] div;
    logic             pll_acc;

    pcd_cfg_reg #(.DIV_W(DIV_W)) u_cfg (
        .clk     (clk),
        .rst_n   (rst_n),
        .we      (cfg_we),
        .wr_src  (cfg_wdata[SRC_BIT]),
        .wr_gate (cfg_wdata[GATE_BIT]),
        .wr_div  (cfg_wdata[DIV_W-1:0]),
        .src_o   (src),
        .gate_o  (gate),
        .div_o   (div)
    );

    pcd_prescale u_pre (
        .clk      (clk),
        .rst_n    (rst_n),
        .hold     (gate),
        .pll_tick (pll_tick),
        .pll_full (pll_full),
        .tick_o   (pll_acc)
    );

    pcd_divider #(.DIV_W(DIV_W)) u_div (
        .clk      (clk),
        .rst_n    (rst_n),
        .gate     (gate),
        .src      (src),
        .ext_tick (ext_tick),
        .pll_tick (pll_acc),
        .div      (div),
        .stb      (clk_stb)
    );

    // Readback word assembled from the stored fields.
    generate
        if (RW == DIV_W + 2) begin : g_rd
            always_comb cfg_rdata = {logic'(src), gate, div};
        end
    endgenerate
endmodule

// File: rtl/periph_clk_div_chk.sv
// Assertion checker for periph_clk_div, attached by bind.
// Assumes the register layout {source, gate, divisor}.
module periph_clk_div_chk #(
    parameter int unsigned DIV_W = 9
) (
    input logic             clk,
    input logic             rst_n,
    input logic             ext_tick,
    input logic             pll_tick,
    input logic             pll_full,
    input logic             cfg_we,
    input logic [DIV_W+1:0] cfg_wdata,
    input logic [DIV_W+1:0] cfg_rdata,
    input logic             clk_stb
);
    localparam int unsigned GB = DIV_W;
    localparam int unsigned SB = DIV_W + 1;
    localparam logic [DIV_W+1:0] RST_WORD = (DIV_W+2)'(1) << DIV_W;

    p_reset_word_r1: assert property (@(posedge clk)
        !rst_n |=> (cfg_rdata == RST_WORD && !clk_stb));

    p_gated_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_rdata[GB] |=> !clk_stb);

    p_ext_follow_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!cfg_rdata[SB] && !cfg_rdata[GB]) |=> (clk_stb == $past(ext_tick)));

    p_pll_needs_tick_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_rdata[SB] && !pll_tick) |=> !clk_stb);

    p_half_spacing_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(!pll_full) && !pll_full && clk_stb && cfg_rdata[SB]) |=> !clk_stb);

    p_src_locked_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_rdata[GB] |=> (cfg_rdata[SB] == $past(cfg_rdata[SB])));

    p_write_visible_r8: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_we |=> (cfg_rdata[DIV_W:0] == $past(cfg_wdata[DIV_W:0])));
endmodule

bind periph_clk_div periph_clk_div_chk #(.DIV_W(DIV_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .ext_tick  (ext_tick),
    .pll_tick  (pll_tick),
    .pll_full  (pll_full),
    .cfg_we    (cfg_we),
    .cfg_wdata (cfg_wdata),
    .cfg_rdata (cfg_rdata),
    .clk_stb   (clk_stb)
);

// File: tb/tb_periph_clk_div.sv
`timescale 1ns/1ps
module tb_periph_clk_div;
    localparam int DIV_W = 9;
    localparam int RW    = DIV_W + 2;
    localparam int NV    = 8;
    localparam int WIN   = 24;

    // Vector table: source, full-rate, divisor, expected strobes in WIN cycles.
    localparam int V_SRC [NV] = '{0,   0, 1, 1, 1, 1, 1, 1};
    localparam int V_FULL[NV] = '{1,   0, 1, 1, 1, 0, 0, 1};
    localparam int V_DIV [NV] = '{5, 511, 0, 3, 5, 0, 2, 7};
    localparam int V_EXP [NV] = '{8,   8, 24, 6, 4, 12, 4, 3};

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          ext_tick = 1'b0;
    logic          pll_tick = 1'b0;
    logic          pll_full = 1'b1;
    logic          cfg_we = 1'b0;
    logic [RW-1:0] cfg_wdata = '0;
    logic [RW-1:0] cfg_rdata;
    logic          clk_stb;

    int checks = 0;
    int errors = 0;
    bit done   = 0;

    always #4 clk = ~clk;

    periph_clk_div #(.DIV_W(DIV_W)) dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .ext_tick  (ext_tick),
        .pll_tick  (pll_tick),
        .pll_full  (pll_full),
        .cfg_we    (cfg_we),
        .cfg_wdata (cfg_wdata),
        .cfg_rdata (cfg_rdata),
        .clk_stb   (clk_stb)
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic cyc(input logic e, input logic p);
        ext_tick = e;
        pll_tick = p;
        @(posedge clk);
        #1;
    endtask

    task automatic wr(input logic s, input logic g, input int d);
        cfg_we    = 1'b1;
        cfg_wdata = {s, g, DIV_W'(d)};
        cyc(1'b0, 1'b0);
        cfg_we    = 1'b0;
    endtask

    initial begin
        #(200000 * 8);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        int n;
        repeat (3) @(posedge clk);
        #1;
        rst_n = 1'b1;

        // R1 / R8: reset readback {src=0, gate=1, div=0}
        check("R1 reset word", int'(cfg_rdata), 1 << DIV_W);
        // R2: gated at reset, ticks give nothing
        n = 0;
        for (int i = 0; i < 6; i++) begin cyc(1'b1, 1'b1); n += int'(clk_stb); end
        check("R1 R2 no strobe after reset", n, 0);

        // Table walk: R3 ext bypass, R4 full rate, R5 half rate
        for (int v = 0; v < NV; v++) begin
            pll_full = V_FULL[v][0];
            wr(V_SRC[v][0], 1'b1, V_DIV[v]);
            wr(V_SRC[v][0], 1'b0, V_DIV[v]);
            n = 0;
            for (int i = 0; i < WIN; i++) begin
                cyc((i % 3) == 0, 1'b1);
                n += int'(clk_stb);
            end
            check($sformatf("R3 R4 R5 vector %0d", v), n, V_EXP[v]);
            wr(V_SRC[v][0], 1'b1, V_DIV[v]);
        end

        // R8: readback layout after a write
        wr(1'b1, 1'b1, 37);
        check("R8 readback", int'(cfg_rdata), (1 << (DIV_W + 1)) | (1 << DIV_W) | 37);

        // R7: clean restart after ungating, full rate, divisor 3
        pll_full = 1'b1;
        wr(1'b1, 1'b1, 3);
        wr(1'b1, 1'b0, 3);
        n = 0;
        for (int i = 0; i < 3; i++) begin cyc(1'b0, 1'b1); n += int'(clk_stb); end
        check("R7 quiet before first period", n, 0);
        cyc(1'b0, 1'b1);
        check("R7 strobe on fourth tick", int'(clk_stb), 1);

        // R2: gating while running stops the output
        cyc(1'b0, 1'b1);
        wr(1'b1, 1'b1, 3);
        check("R2 gate readback", int'(cfg_rdata[DIV_W]), 1);
        n = 0;
        for (int i = 0; i < 10; i++) begin cyc(1'b1, 1'b1); n += int'(clk_stb); end
        check("R2 gated output", n, 0);

        // R6: source change refused while running
        wr(1'b1, 1'b0, 3);
        wr(1'b0, 1'b0, 3);
        check("R6 source kept", int'(cfg_rdata[DIV_W + 1]), 1);
        n = 0;
        for (int i = 0; i < 6; i++) begin cyc(1'b1, 1'b0); n += int'(clk_stb); end
        check("R6 ext ticks ignored on PLL source", n, 0);

        // R9: divisor lowered below the running count
        wr(1'b1, 1'b1, 7);
        wr(1'b1, 1'b0, 7);
        n = 0;
        for (int i = 0; i < 5; i++) begin cyc(1'b0, 1'b1); n += int'(clk_stb); end
        check("R9 no strobe in long period", n, 0);
        wr(1'b1, 1'b0, 2);
        cyc(1'b0, 1'b1);
        check("R9 immediate strobe", int'(clk_stb), 1);
        n = 0;
        for (int i = 0; i < 2; i++) begin cyc(1'b0, 1'b1); n += int'(clk_stb); end
        cyc(1'b0, 1'b1);
        check("R9 new period length", n * 10 + int'(clk_stb), 1);

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule